// File: doc/BRIEF.md
# Outbound Transaction Ordering Arbiter

This block decides which of three outbound transaction classes leaves next: posted requests, non-posted requests and completions. Each class presents only the entry at the head of its queue, as a valid flag, an arrival sequence tag and a relaxed-ordering flag. A per-class space signal reports whether the downstream buffer for that class can take a transaction this cycle. When every head can move, transactions leave in the order they arrived. A head may overtake an older head of another class only while that older head is stalled, and only where the ordering rules between the two classes allow it.

The head views behave as valid/ready streams whose ready is the grant: a head stays valid with stable tag and flag until its class is granted, and the grant is the pop. Space low on a class is back-pressure; the head waits and nothing is lost. The decision is combinational, so a grant appears in the same cycle as the head views and space signals that justify it. Sequence tags come from an 8-bit wrapping counter and are compared modulo 256, so pending transactions must span fewer than 128 tag values.

Top module: `ord_arbiter`

## Requirements
- R1: When every valid head has its space signal high, the grant goes to the head with the oldest tag.
- R2: At most one grant bit is set per cycle; a grant goes only to a head that is valid with space high, and grant_tag equals that head's tag. Grant bit 0 is posted, bit 1 non-posted, bit 2 completion.
- R3: No grant is given while rst_n is low, when no head is valid, or when no valid head is both allowed to move and has space.
- R4: A posted head may overtake older stalled non-posted and completion heads, whatever its relaxed-ordering flag.
- R5: A completion head may overtake an older stalled non-posted head whatever its relaxed-ordering flag.
- R6: A completion head may overtake an older stalled posted head only when its own relaxed-ordering flag is 1; otherwise it is not granted.
- R7: A non-posted head never overtakes an older posted head, even with its relaxed-ordering flag at 1.
- R8: A non-posted head may overtake an older stalled completion head only when its own relaxed-ordering flag is 1.
- R9: Among several heads that are allowed to move and have space, the oldest wins; age is taken from the 8-bit difference of tags, so tag 8'hFE is older than tag 8'h01.
- R10: A head that may not move does not block a younger head of another class that is allowed to overtake every older pending head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the assertion sampling |
| rst_n | input | 1 | Active-low reset; holds grant at zero |
| p_valid | input | 1 | Posted head present |
| p_tag | input | TAG_W | Posted head arrival tag |
| p_ro | input | 1 | Posted head relaxed-ordering flag |
| np_valid | input | 1 | Non-posted head present |
| np_tag | input | TAG_W | Non-posted head arrival tag |
| np_ro | input | 1 | Non-posted head relaxed-ordering flag |
| cpl_valid | input | 1 | Completion head present |
| cpl_tag | input | TAG_W | Completion head arrival tag |
| cpl_ro | input | 1 | Completion head relaxed-ordering flag |
| space | input | 3 | Downstream room per class, bit order as grant |
| grant | output | 3 | One-hot grant: bit 0 posted, 1 non-posted, 2 completion |
| grant_tag | output | TAG_W | Tag of the granted head, zero when no grant |

## Verification
Every result of this block is due in the same cycle as the inputs that cause it, since no register lies between the head views and the grant. The bench therefore changes inputs one time unit after a rising edge and reads grant and grant_tag at the following falling edge, half a period later, once the decision has settled and well before the next change. Reset behaviour is read the same way while rst_n is held low with heads offered, and an exhaustive sweep of valid, relaxed-ordering and space patterns under four tag orderings, including a wrapped one, is compared against a rule model written from the requirements.

// File: rtl/ord_pkg.sv
package ord_pkg;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    CLS_P = 2'd0,
    CLS_N = 2'd1,
    CLS_C = 2'd2
  } cls_e;

  // Whether a head of class mover may leave ahead of an older head of
  // class blocker, given the mover's relaxed-ordering flag.
  function automatic logic may_pass(input int mover, input int blocker, input logic ro);
    logic ok;
    ok = 1'b0;
    case (mover)
      CLS_P: ok = (blocker != CLS_P);
      CLS_C: ok = (blocker == CLS_N) ? 1'b1 : (blocker == CLS_P) ? ro : 1'b0;
      CLS_N: ok = (blocker == CLS_C) ? ro : 1'b0;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/ord_elig.sv
module ord_elig
  import ord_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [NCLS-1:0]            vld,
  input  logic [NCLS-1:0]            ro,
  input  logic [NCLS-1:0][TAG_W-1:0] tag,
  output logic [NCLS-1:0]            elig
);
  localparam int AGE_MSB = TAG_W - 1;

  function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[AGE_MSB];
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < NCLS; gi++) begin : g_cls
      always_comb begin
        elig[gi] = vld[gi];
        for (int j = 0; j < NCLS; j++) begin
          if (j != gi && vld[j] && older(tag[j], tag[gi]) && !may_pass(gi, j, ro[gi]))
            elig[gi] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ord_pick.sv
module ord_pick
  import ord_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [NCLS-1:0]            cand,
  input  logic [NCLS-1:0][TAG_W-1:0] tag,
  output logic [NCLS-1:0]            gnt,
  output logic [TAG_W-1:0]           gnt_tag
);
  localparam int AGE_MSB = TAG_W - 1;

  function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[AGE_MSB];
  endfunction

  logic [NCLS-1:0] win;

  genvar gi;
  generate
    for (gi = 0; gi < NCLS; gi++) begin : g_win
      always_comb begin
        win[gi] = cand[gi];
        for (int j = 0; j < NCLS; j++) begin
          if (j != gi && cand[j] && older(tag[j], tag[gi]))
            win[gi] = 1'b0;
        end
      end
    end
  endgenerate

  // Equal tags are outside the contract; lowest class index breaks the tie.
  always_comb begin
    gnt = '0;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (win[i]) gnt = NCLS'(1) << i;
    end
  end

  always_comb begin
    gnt_tag = '0;
    for (int i = 0; i < NCLS; i++) begin
      gnt_tag = gnt_tag | (tag[i] & {TAG_W{gnt[i]}});
    end
  end
endmodule

// File: rtl/ord_arbiter.sv
module ord_arbiter
  import ord_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_valid,
  input  logic [TAG_W-1:0]  p_tag,
  input  logic              p_ro,
  input  logic              np_valid,
  input  logic [TAG_W-1:0]  np_tag,
  input  logic              np_ro,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic              cpl_ro,
  input  logic [2:0]        space,
  output logic [2:0]        grant,
  output logic [TAG_W-1:0]  grant_tag
);
  localparam int AGE_MSB = TAG_W - 1;

  logic [NCLS-1:0]            vld, ro, elig, cand, pick;
  logic [NCLS-1:0][TAG_W-1:0] tags;
  logic [TAG_W-1:0]           pick_tag;

  assign vld  = {cpl_valid, np_valid, p_valid};
  assign ro   = {cpl_ro, np_ro, p_ro};
  assign tags = {cpl_tag, np_tag, p_tag};

  ord_elig #(.TAG_W(TAG_W)) u_elig (
    .vld (vld),
    .ro  (ro),
    .tag (tags),
    .elig(elig)
  );

  assign cand = elig & space;

  ord_pick #(.TAG_W(TAG_W)) u_pick (
    .cand   (cand),
    .tag    (tags),
    .gnt    (pick),
    .gnt_tag(pick_tag)
  );

  assign grant     = rst_n ? pick : '0;
  assign grant_tag = rst_n ? pick_tag : '0;

  function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[AGE_MSB];
  endfunction

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & vld & space) == grant));
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld & space) == '0) |-> (grant == '0));
  a_r1_order: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld & space) == vld && p_valid && np_valid && older(p_tag, np_tag)) |-> !grant[1]);
  a_r6_cpl_p: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[2] && p_valid && !cpl_ro) |-> older(cpl_tag, p_tag));
  a_r7_np_p: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[1] && p_valid) |-> older(np_tag, p_tag));
  a_r8_np_c: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[1] && cpl_valid && !np_ro) |-> older(np_tag, cpl_tag));
endmodule

// File: tb/sim_ord_arbiter.sv
`timescale 1ns/1ps
module sim_ord_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_valid = 0, np_valid = 0, cpl_valid = 0;
  logic p_ro = 0, np_ro = 0, cpl_ro = 0;
  logic [7:0] p_tag = 0, np_tag = 0, cpl_tag = 0;
  logic [2:0] space = 0;
  logic [2:0] grant;
  logic [7:0] grant_tag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ord_arbiter #(.TAG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .p_valid(p_valid), .p_tag(p_tag), .p_ro(p_ro),
    .np_valid(np_valid), .np_tag(np_tag), .np_ro(np_ro),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_ro(cpl_ro),
    .space(space), .grant(grant), .grant_tag(grant_tag)
  );

  // {valid CNP, ro CNP, space CNP, p_tag, np_tag, cpl_tag, expected grant CNP}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {3'b111, 3'b000, 3'b111, 8'd10, 8'd20, 8'd30, 3'b001}, // R1 posted oldest
    {3'b111, 3'b000, 3'b111, 8'd30, 8'd10, 8'd20, 3'b010}, // R1 non-posted oldest
    {3'b111, 3'b000, 3'b001, 8'd30, 8'd10, 8'd20, 3'b001}, // R4 posted passes both
    {3'b110, 3'b000, 3'b100, 8'd0,  8'd10, 8'd20, 3'b100}, // R5 completion passes NP
    {3'b101, 3'b000, 3'b100, 8'd10, 8'd0,  8'd20, 3'b000}, // R6 no RO: blocked
    {3'b101, 3'b100, 3'b100, 8'd10, 8'd0,  8'd20, 3'b100}, // R6 RO: passes
    {3'b011, 3'b010, 3'b010, 8'd10, 8'd20, 8'd0,  3'b000}, // R7 RO does not help
    {3'b110, 3'b000, 3'b010, 8'd0,  8'd20, 8'd10, 3'b000}, // R8 no RO: blocked
    {3'b110, 3'b010, 3'b010, 8'd0,  8'd20, 8'd10, 3'b010}, // R8 RO: passes
    {3'b111, 3'b000, 3'b111, 8'h02, 8'hFE, 8'h01, 3'b010}, // R9 wrapped age
    {3'b110, 3'b010, 3'b110, 8'd0,  8'd20, 8'd10, 3'b100}, // R9 oldest of two
    {3'b111, 3'b100, 3'b110, 8'd10, 8'd20, 8'd30, 3'b100}, // R10 skip blocked NP
    {3'b000, 3'b000, 3'b111, 8'd10, 8'd20, 8'd30, 3'b000}, // R3 nothing valid
    {3'b111, 3'b000, 3'b000, 8'd10, 8'd20, 8'd30, 3'b000}  // R3 no space
  };

  function automatic logic older(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return d[7];
  endfunction

  // Rule table from the requirements: 0 posted, 1 non-posted, 2 completion.
  function automatic logic allowed(input int m, input int b, input logic r);
    if (m == 0) return 1'b1;
    if (m == 2) return (b == 1) ? 1'b1 : r;
    return (b == 2) ? r : 1'b0;
  endfunction

  function automatic logic [2:0] ref_pick(input logic [2:0] v, input logic [2:0] r,
                                          input logic [2:0] s, input logic [7:0] t0,
                                          input logic [7:0] t1, input logic [7:0] t2);
    logic [7:0] t [3];
    logic [2:0] ok, res;
    t[0] = t0; t[1] = t1; t[2] = t2;
    for (int i = 0; i < 3; i++) begin
      ok[i] = v[i] & s[i];
      for (int j = 0; j < 3; j++)
        if (j != i && v[j] && older(t[j], t[i]) && !allowed(i, j, r[i])) ok[i] = 1'b0;
    end
    res = '0;
    for (int i = 0; i < 3; i++) begin
      logic best;
      best = ok[i];
      for (int j = 0; j < 3; j++)
        if (j != i && ok[j] && older(t[j], t[i])) best = 1'b0;
      if (best) res[i] = 1'b1;
    end
    return res;
  endfunction

  task automatic drive(input logic [2:0] v, input logic [2:0] r, input logic [2:0] s,
                       input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2);
    @(posedge clk); #1;
    {cpl_valid, np_valid, p_valid} = v;
    {cpl_ro, np_ro, p_ro} = r;
    space = s;
    p_tag = t0; np_tag = t1; cpl_tag = t2;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] eg, input logic [7:0] et);
    checks++;
    if (grant !== eg || grant_tag !== et) begin
      fails++;
      $display("FAIL %s: grant=%b tag=%0h expected grant=%b tag=%0h", req, grant, grant_tag, eg, et);
    end
  endtask

  function automatic logic [7:0] tag_of(input logic [2:0] g, input logic [7:0] t0,
                                        input logic [7:0] t1, input logic [7:0] t2);
    return g[0] ? t0 : g[1] ? t1 : g[2] ? t2 : 8'd0;
  endfunction

  initial begin
    logic [7:0] ts [4][3];
    ts[0] = '{8'd10, 8'd20, 8'd30};
    ts[1] = '{8'd30, 8'd10, 8'd20};
    ts[2] = '{8'd20, 8'd30, 8'd10};
    ts[3] = '{8'hFD, 8'h02, 8'hFF};

    // R3: reset holds the grant low even with heads offered
    drive(3'b111, 3'b000, 3'b111, 8'd1, 8'd2, 8'd3);
    check("R3 reset", 3'b000, 8'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 3'b001, 8'd1);

    for (int k = 0; k < NV; k++) begin
      logic [35:0] w;
      w = VEC[k];
      drive(w[35:33], w[32:30], w[29:27], w[26:19], w[18:11], w[10:3]);
      check($sformatf("R2 vector %0d", k), w[2:0], tag_of(w[2:0], w[26:19], w[18:11], w[10:3]));
    end

    // R2 R4 R5 R6 R7 R8 R9 R10: exhaustive sweep against the rule model
    for (int o = 0; o < 4; o++) begin
      for (int c = 0; c < 512; c++) begin
        logic [8:0] cv;
        logic [2:0] eg;
        cv = 9'(c);
        eg = ref_pick(cv[8:6], cv[5:3], cv[2:0], ts[o][0], ts[o][1], ts[o][2]);
        drive(cv[8:6], cv[5:3], cv[2:0], ts[o][0], ts[o][1], ts[o][2]);
        check($sformatf("R2 sweep o=%0d c=%0d", o, c), eg, tag_of(eg, ts[o][0], ts[o][1], ts[o][2]));
      end
    end

    // R3: reset asserted again mid-run
    drive(3'b111, 3'b000, 3'b111, 8'd5, 8'd6, 8'd7);
    #1 rst_n = 1'b0;
    #1 check("R3 reset mid-run", 3'b000, 8'd0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule